// File: doc/BRIEF.md
# Wiper Step Sequencer for an Up/Down Digital Potentiometer

This block lets on-chip logic move the wiper of an external digital potentiometer. The potentiometer has a three-wire up/down interface: an active-low select, a direction level, and an active-low step strobe. The host hands over one command on a valid/ready handshake. A command holds a step count, a direction, and a flag that says whether the final position should be written to the target's nonvolatile memory.

The sequencer selects the target and waits out the select and direction setup times. It then issues the requested number of step strobes, each meeting the low-time, high-time and full-period minimums. It leaves the strobe line at the level that picks commit or discard, holds it still for the required time, and deselects. It accepts nothing further until the deselect recovery time has elapsed, and it marks that moment with a one-cycle done pulse.

Every timing minimum is a parameter counted in clock cycles, so the integrator rounds each one up to whole cycles of the local clock. A count of zero still performs a full select/deselect. With the commit flag set, this rewrites the unchanged position into memory.

Top module: `wiper_stepper`

## Requirements
- R1: After reset and whenever no command is in progress, `pot_cs_n` and `pot_inc_n` are both 1 and `cmd_ready` is 1.
- R2: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the recovery time ends, and `cmd_valid` has no effect during that time.
- R3: `pot_cs_n` is 0 for at least max(`CS_SETUP`, `DIR_SETUP`) cycles before the first falling edge of `pot_inc_n`.
- R4: Each low phase of `pot_inc_n` inside a selection lasts at least `INC_LOW` cycles. Each high phase between two strobes lasts at least `INC_HIGH` cycles. Two successive falling edges are at least `INC_PERIOD` cycles apart.
- R5: The number of falling edges of `pot_inc_n` while `pot_cs_n` is 0 equals `cmd_steps`. `pot_up` equals `cmd_up` (1 = up) from selection to deselection and does not change within it.
- R6: With `cmd_store` = 1, `pot_inc_n` is 1 when `pot_cs_n` rises (commit).
- R7: With `cmd_store` = 0, `pot_inc_n` is 0 when `pot_cs_n` rises (discard). This holds for a zero step count too, where the strobe is lowered before selection so that no falling edge occurs while selected.
- R8: `pot_inc_n` does not change during the `INC_TO_CS` cycles before `pot_cs_n` rises, and does not change in the cycle `pot_cs_n` rises.
- R9: After `pot_cs_n` rises, it stays 1 for exactly `DESELECT` cycles before `cmd_ready` returns to 1. `done` is 1 for exactly that one cycle.
- R10: A `cmd_steps` of 0 produces a select/deselect with no strobe edge while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_steps | input | STEP_W | Number of wiper steps |
| cmd_up | input | 1 | Direction, 1 = up |
| cmd_store | input | 1 | 1 = commit position at deselect, 0 = discard |
| pot_cs_n | output | 1 | Target select, active low |
| pot_inc_n | output | 1 | Step strobe, target acts on its falling edge |
| pot_up | output | 1 | Direction level to target |
| done | output | 1 | One-cycle pulse when recovery ends |

## Verification
The bench goes after the zero-step commands in both flag settings. A design that forgot to pre-lower the strobe would commit when asked to discard. One that lowered it while selected would add a phantom step. The one-step discard case matters because the final low phase must run straight into deselection. A design that returned the strobe high first would commit, or would deselect too early and break the hold. Back-to-back commands, with the next one already offered during recovery, expose any early acceptance or a recovery count that is off by one. The 31-step run exposes counter underflow and period violations at the top of the count range.

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int STEP_W     = 5,
  parameter int CS_SETUP   = 10,
  parameter int DIR_SETUP  = 290,
  parameter int INC_LOW    = 100,
  parameter int INC_HIGH   = 100,
  parameter int INC_PERIOD = 400,
  parameter int INC_TO_CS  = 100,
  parameter int DESELECT   = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_up,
  input  logic              cmd_store,
  output logic              pot_cs_n,
  output logic              pot_inc_n,
  output logic              pot_up,
  output logic              done
);

  localparam int HIGH_T = (INC_HIGH > INC_PERIOD - INC_LOW) ? INC_HIGH : INC_PERIOD - INC_LOW;
  localparam int SEL_T  = (CS_SETUP > DIR_SETUP) ? CS_SETUP : DIR_SETUP;
  localparam int M1     = (SEL_T > HIGH_T) ? SEL_T : HIGH_T;
  localparam int M2     = (INC_LOW > INC_TO_CS) ? INC_LOW : INC_TO_CS;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int MAXT   = (M3 > DESELECT) ? M3 : DESELECT;
  localparam int TW     = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SEL, S_LOW, S_HIGH, S_TAIL, S_REC} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [STEP_W-1:0] left;
  logic              keep;
  logic              cs_q, inc_q, up_q, done_q;

  wire expire = (tmr == '0);

  assign cmd_ready = (st == S_IDLE);
  assign pot_cs_n  = cs_q;
  assign pot_inc_n = inc_q;
  assign pot_up    = up_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      left   <= '0;
      keep   <= 1'b0;
      cs_q   <= 1'b1;
      inc_q  <= 1'b1;
      up_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!expire) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: begin
          cs_q  <= 1'b1;
          inc_q <= 1'b1;
          if (cmd_valid) begin
            left <= cmd_steps;
            keep <= cmd_store;
            up_q <= cmd_up;
            if (cmd_steps == '0 && !cmd_store) begin
              st    <= S_PRE;
              inc_q <= 1'b0;
              tmr   <= '0;
            end else begin
              st   <= S_SEL;
              cs_q <= 1'b0;
              tmr  <= TW'(SEL_T - 1);
            end
          end
        end
        S_PRE: if (expire) begin
          st   <= S_SEL;
          cs_q <= 1'b0;
          tmr  <= TW'(SEL_T - 1);
        end
        S_SEL: if (expire) begin
          if (left == '0) begin
            st  <= S_TAIL;
            tmr <= TW'(INC_TO_CS - 1);
          end else begin
            st    <= S_LOW;
            inc_q <= 1'b0;
            tmr   <= TW'(INC_LOW - 1);
          end
        end
        S_LOW: if (expire) begin
          left <= left - 1'b1;
          if (left == STEP_W'(1) && !keep) begin
            st  <= S_TAIL;
            tmr <= TW'(INC_TO_CS - 1);
          end else begin
            st    <= S_HIGH;
            inc_q <= 1'b1;
            tmr   <= TW'(HIGH_T - 1);
          end
        end
        S_HIGH: if (expire) begin
          if (left == '0) begin
            st  <= S_TAIL;
            tmr <= TW'(INC_TO_CS - 1);
          end else begin
            st    <= S_LOW;
            inc_q <= 1'b0;
            tmr   <= TW'(INC_LOW - 1);
          end
        end
        S_TAIL: if (expire) begin
          st   <= S_REC;
          cs_q <= 1'b1;
          tmr  <= TW'(DESELECT - 1);
        end
        S_REC: begin
          inc_q <= 1'b1;
          if (expire) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pot_cs_n && pot_inc_n)); // R1

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R2

  AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pot_inc_n) && !pot_cs_n) |-> !$past(pot_cs_n)); // R3

  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pot_cs_n && !$past(pot_cs_n)) |-> $stable(pot_up)); // R5

  AST_STROBE_QUIET_AT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pot_cs_n) |-> $stable(pot_inc_n)); // R8

  AST_DONE_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && pot_cs_n)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

// File: tb/tb_wiper_stepper.sv
module tb_wiper_stepper;
  localparam int STEP_W = 5, CS_SETUP = 3, DIR_SETUP = 5, INC_LOW = 4, INC_HIGH = 3,
                 INC_PERIOD = 10, INC_TO_CS = 4, DESELECT = 20;
  localparam int SEL_T = (CS_SETUP > DIR_SETUP) ? CS_SETUP : DIR_SETUP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, cmd_store = 1'b0;
  logic [STEP_W-1:0] cmd_steps = '0;
  logic cmd_ready, pot_cs_n, pot_inc_n, pot_up, done;

  always #5 clk = ~clk;

  wiper_stepper #(.STEP_W(STEP_W), .CS_SETUP(CS_SETUP), .DIR_SETUP(DIR_SETUP), .INC_LOW(INC_LOW),
    .INC_HIGH(INC_HIGH), .INC_PERIOD(INC_PERIOD), .INC_TO_CS(INC_TO_CS), .DESELECT(DESELECT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_steps(cmd_steps),
    .cmd_up(cmd_up), .cmd_store(cmd_store), .pot_cs_n(pot_cs_n), .pot_inc_n(pot_inc_n),
    .pot_up(pot_up), .done(done));

  typedef struct packed { logic [STEP_W-1:0] steps; logic up; logic store; } item_t;
  item_t exp_q[$];
  item_t cur;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic send(input int steps, input bit up, input bit store);
    item_t it;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_steps = STEP_W'(steps);
    cmd_up = up;
    cmd_store = store;
    while (!cmd_ready) @(negedge clk);
    it.steps = STEP_W'(steps);
    it.up = up;
    it.store = store;
    exp_q.push_back(it);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R2 ready low after take", int'(cmd_ready), 0);
  endtask

  bit prev_cs = 1, prev_inc = 1, in_rec = 0;
  int cs_low_run = 0, inc_run = 0, gap = 0, falls = 0, rec_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !pot_cs_n) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected selection", 1, 0);
          cur = '0;
        end else cur = exp_q.pop_front();
        falls = 0;
        cs_low_run = 0;
        chk(pot_up == cur.up, "R5 direction at select", int'(pot_up), int'(cur.up));
      end else if (!prev_cs && !pot_cs_n) begin
        if (prev_inc && !pot_inc_n) begin
          if (falls == 0) chk(cs_low_run >= SEL_T, "R3 select setup", cs_low_run, SEL_T);
          else begin
            chk(gap >= INC_PERIOD, "R4 strobe period", gap, INC_PERIOD);
            chk(inc_run >= INC_HIGH, "R4 high time", inc_run, INC_HIGH);
          end
          chk(pot_up == cur.up, "R5 direction at strobe", int'(pot_up), int'(cur.up));
          falls++;
          gap = 0;
        end
        if (!prev_inc && pot_inc_n) chk(inc_run >= INC_LOW, "R4 low time", inc_run, INC_LOW);
      end else if (!prev_cs && pot_cs_n) begin
        chk(pot_inc_n == prev_inc && inc_run >= INC_TO_CS, "R8 strobe quiet before deselect", inc_run, INC_TO_CS);
        chk(falls == int'(cur.steps), cur.steps == 0 ? "R10 no strobe for zero count" : "R5 step count",
            falls, int'(cur.steps));
        chk(pot_inc_n == cur.store, cur.store ? "R6 commit level" : "R7 discard level",
            int'(pot_inc_n), int'(cur.store));
        in_rec = 1;
        rec_cnt = 0;
      end
      if (in_rec) begin
        if (cmd_ready) begin
          chk(rec_cnt == DESELECT, "R9 recovery length", rec_cnt, DESELECT);
          chk(done == 1'b1, "R9 done pulse", int'(done), 1);
          chk(pot_cs_n && pot_inc_n, "R1 idle levels", int'({pot_cs_n, pot_inc_n}), 3);
          in_rec = 0;
        end else if (pot_cs_n) rec_cnt++;
      end
      if (pot_inc_n == prev_inc) inc_run++; else inc_run = 1;
      if (!pot_cs_n) cs_low_run++;
      gap++;
      prev_cs = pot_cs_n;
      prev_inc = pot_inc_n;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pot_cs_n && pot_inc_n, "R1 reset levels", int'({pot_cs_n, pot_inc_n}), 3);
    chk(done == 1'b0, "R1 done idle", int'(done), 0);
    send(3, 1, 1);
    send(0, 1, 1);
    send(0, 0, 0);
    send(1, 1, 0);
    send(5, 0, 0);
    send(31, 1, 1);
    send(2, 0, 1);
    while (exp_q.size() != 0 || !cmd_ready || in_rec || !pot_cs_n) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(pot_cs_n && pot_inc_n && cmd_ready, "R1 final idle", int'({pot_cs_n, pot_inc_n, cmd_ready}), 7);
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end
endmodule